// File: doc/BRIEF.md
# BCD Calendar Field Stepper

This block holds a packed-BCD time word and a packed-BCD date word for a real-time clock and lets a host adjust them one field at a time. The host picks a field through a mode register and then commits a single increment of that field through a two-write handshake on a control register. Each field wraps inside its own legal range, and an increment never carries into a neighbouring field. Free-running seconds counting, month-length checks and leap years are left to other logic.

Access is through a word-addressed write port with per-byte write strobes and a separate combinational read port. Word offset 0 is the mode register, offset 1 the control register, offset 2 the time word and offset 3 the date word. Time and date can only be changed by committed increments.

Top module: `rtc_field_stepper`

## Requirements
- R1: After reset the words read at offsets 0, 1, 2 and 3 are all zero.
- R2: A write to offset 0 stores the data into the mode register byte by byte, only the bytes whose strobe bit (bit n for data bits 8n+7:8n) is set; a write to offset 1 while the control register reads 0 stores into control the same way.
- R3: A write of exactly 32'h1 to offset 1 while control reads 1 commits one increment of the selected field and leaves control at 0; any other control write while control is not 0 leaves control unchanged.
- R4: The selected field is mode bits 3:1: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 low year; code 7 commits with no change to time or date.
- R5: Seconds (time bits 7:0) and minutes (time bits 15:8) count 00 to 59 in BCD, with 0x09 stepping to 0x10 and 0x59 wrapping to 0x00.
- R6: Hours (time bits 23:16) count 00 to 23 in BCD; 0x09 steps to 0x10 and 0x23 wraps to 0x00.
- R7: Weekday (time bits 27:24) steps 0 to 1, counts up to 7, and 7 wraps to 1.
- R8: Day (date bits 7:0) counts 00 to 31 in BCD and 0x31 wraps to 0x00; month (date bits 15:8) counts up to 0x12, which wraps to 0x01.
- R9: Low year (date bits 23:16) counts 00 to 99 in BCD and 0x99 wraps to 0x00.
- R10: A committed increment changes no bit of time or date outside the selected field.
- R11: Writes to offsets 2, 3 and any offset above 3 change nothing readable; reads from offsets above 3 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request for this cycle |
| wr_addr | input | ADDR_W | Word offset of the write |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes for the write |
| rd_addr | input | ADDR_W | Word offset of the read |
| rd_data | output | 32 | Read data for rd_addr, combinational |

## Verification
Every field is stepped through its full cycle from zero, so each BCD tens carry and each wrap point (59, 23, 7, 31, 12, 99) is reached and compared with a decimal model that knows nothing of nibble arithmetic. Random mixes of mode writes with partial strobes, control writes of 0, 1 and arbitrary values, and writes to the read-only and unused offsets separate a correct handshake from one that commits on the first write, ignores the strobes, or lets a stuck control value be overwritten. Selector code 7 and checks of all four words after every operation show that no increment leaks into a neighbouring field.

// File: rtl/rtc_fs_pkg.sv
package rtc_fs_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LANES   = WORD_W / 8;

  localparam int unsigned OFS_MODE = 0;
  localparam int unsigned OFS_CTRL = 1;
  localparam int unsigned OFS_TIME = 2;
  localparam int unsigned OFS_DATE = 3;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_WDAY = 3'd3,
    SEL_DAY  = 3'd4,
    SEL_MON  = 3'd5,
    SEL_YEAR = 3'd6,
    SEL_NONE = 3'd7
  } field_sel_e;
endpackage

// File: rtl/rtc_fs_bcd_byte.sv
// One packed-BCD byte incremented by one, with a tens carry and a wrap point.
// WRAP_FIRST = 1 compares the raw sum with WRAP_AT before the tens carry,
// otherwise the carried value is compared.
module rtc_fs_bcd_byte #(
  parameter logic [7:0] WRAP_AT    = 8'h60,
  parameter logic [7:0] WRAP_TO    = 8'h00,
  parameter bit         WRAP_FIRST = 1'b0
) (
  input  logic [7:0] cur,
  output logic [7:0] nxt
);
  logic [7:0] sum;
  logic [7:0] carried;

  always_comb begin
    sum     = cur + 8'd1;
    carried = (sum[3:0] == 4'hA) ? {sum[7:4] + 4'd1, 4'h0} : sum;
  end

  generate
    if (WRAP_FIRST) begin : g_wrap_raw
      always_comb nxt = (sum == WRAP_AT) ? WRAP_TO : carried;
    end else begin : g_wrap_carried
      always_comb nxt = (carried == WRAP_AT) ? WRAP_TO : carried;
    end
  endgenerate
endmodule

// File: rtl/rtc_fs_field_step.sv
// Next time and date words for one committed increment of the selected field.
module rtc_fs_field_step
  import rtc_fs_pkg::*;
(
  input  logic [WORD_W-1:0] time_cur,
  input  logic [WORD_W-1:0] date_cur,
  input  field_sel_e        sel,
  output logic [WORD_W-1:0] time_nxt,
  output logic [WORD_W-1:0] date_nxt
);
  logic [7:0] sec_n, min_n, hour_n, day_n, mon_n, year_n;
  logic [3:0] wd_sum, wd_n;

  rtc_fs_bcd_byte #(.WRAP_AT(8'h60), .WRAP_TO(8'h00), .WRAP_FIRST(1'b0))
    u_sec  (.cur(time_cur[7:0]),   .nxt(sec_n));
  rtc_fs_bcd_byte #(.WRAP_AT(8'h60), .WRAP_TO(8'h00), .WRAP_FIRST(1'b0))
    u_min  (.cur(time_cur[15:8]),  .nxt(min_n));
  rtc_fs_bcd_byte #(.WRAP_AT(8'h24), .WRAP_TO(8'h00), .WRAP_FIRST(1'b1))
    u_hour (.cur(time_cur[23:16]), .nxt(hour_n));
  rtc_fs_bcd_byte #(.WRAP_AT(8'h32), .WRAP_TO(8'h00), .WRAP_FIRST(1'b1))
    u_day  (.cur(date_cur[7:0]),   .nxt(day_n));
  rtc_fs_bcd_byte #(.WRAP_AT(8'h13), .WRAP_TO(8'h01), .WRAP_FIRST(1'b1))
    u_mon  (.cur(date_cur[15:8]),  .nxt(mon_n));
  rtc_fs_bcd_byte #(.WRAP_AT(8'hA0), .WRAP_TO(8'h00), .WRAP_FIRST(1'b0))
    u_year (.cur(date_cur[23:16]), .nxt(year_n));

  always_comb begin
    wd_sum = time_cur[27:24] + 4'd1;
    wd_n   = (wd_sum == 4'd8) ? 4'd1 : wd_sum;
  end

  always_comb begin
    time_nxt = time_cur;
    date_nxt = date_cur;
    unique case (sel)
      SEL_SEC:  time_nxt[7:0]   = sec_n;
      SEL_MIN:  time_nxt[15:8]  = min_n;
      SEL_HOUR: time_nxt[23:16] = hour_n;
      SEL_WDAY: time_nxt[27:24] = wd_n;
      SEL_DAY:  date_nxt[7:0]   = day_n;
      SEL_MON:  date_nxt[15:8]  = mon_n;
      SEL_YEAR: date_nxt[23:16] = year_n;
      SEL_NONE: ;
    endcase
  end
endmodule

// File: rtl/rtc_fs_host_regs.sv
// Mode and control registers with byte strobes and the commit handshake.
module rtc_fs_host_regs
  import rtc_fs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_strb,
  output logic [WORD_W-1:0] mode_q,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              commit
);
  logic              hit_mode, hit_ctrl;
  logic              mode_en, ctrl_en;
  logic [WORD_W-1:0] mode_merge, ctrl_merge;
  logic [WORD_W-1:0] mode_d, ctrl_d;

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : g_lane
      assign mode_merge[lane*8 +: 8] = wr_strb[lane] ? wr_data[lane*8 +: 8]
                                                     : mode_q[lane*8 +: 8];
      assign ctrl_merge[lane*8 +: 8] = wr_strb[lane] ? wr_data[lane*8 +: 8]
                                                     : ctrl_q[lane*8 +: 8];
    end
  endgenerate

  always_comb begin
    hit_mode = wr_en && (wr_addr == ADDR_W'(OFS_MODE));
    hit_ctrl = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    commit   = hit_ctrl && (ctrl_q == WORD_W'(1)) && (wr_data == WORD_W'(1));
    mode_en  = hit_mode;
    mode_d   = mode_merge;
    ctrl_en  = commit || (hit_ctrl && (ctrl_q == '0));
    ctrl_d   = commit ? '0 : ctrl_merge;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (mode_en) mode_q <= mode_d;
      if (ctrl_en) ctrl_q <= ctrl_d;
    end
  end
endmodule

// File: rtl/rtc_field_stepper.sv
module rtc_field_stepper
  import rtc_fs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        wr_strb,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data
);
  logic [WORD_W-1:0] mode_q, ctrl_q;
  logic [WORD_W-1:0] time_q, date_q, time_d, date_d;
  logic              commit;
  field_sel_e        sel;

  rtc_fs_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_strb (wr_strb),
    .mode_q  (mode_q),
    .ctrl_q  (ctrl_q),
    .commit  (commit)
  );

  assign sel = field_sel_e'(mode_q[3:1]);

  rtc_fs_field_step u_step (
    .time_cur (time_q),
    .date_cur (date_q),
    .sel      (sel),
    .time_nxt (time_d),
    .date_nxt (date_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
      date_q <= '0;
    end else if (commit) begin
      time_q <= time_d;
      date_q <= date_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      ADDR_W'(OFS_MODE): rd_data = mode_q;
      ADDR_W'(OFS_CTRL): rd_data = ctrl_q;
      ADDR_W'(OFS_TIME): rd_data = time_q;
      ADDR_W'(OFS_DATE): rd_data = date_q;
      default:           rd_data = '0;
    endcase
  end
endmodule

// File: rtl/rtc_fs_checker.sv
module rtc_fs_checker #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [31:0]       mode_q,
  input logic [31:0]       ctrl_q,
  input logic [31:0]       time_q,
  input logic [31:0]       date_q
);
  logic ctrl_wr, fire;
  assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(1));
  assign fire    = ctrl_wr && (ctrl_q == 32'd1) && (wr_data == 32'd1);

  // R3: a commit leaves control at zero
  a_r3_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ctrl_q == 32'd0));

  // R3: a stuck nonzero control value is not overwritten
  a_r3_ctrl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !fire && (ctrl_q != 32'd0)) |=> $stable(ctrl_q));

  // R11: time and date move only on a commit
  a_r11_no_stray_change: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(time_q) && $stable(date_q)));

  // R4: code 7 changes nothing
  a_r4_code7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode_q[3:1] == 3'd7)) |=> ($stable(time_q) && $stable(date_q)));

  // R10: a seconds step leaves every other bit alone
  a_r10_sec_local: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode_q[3:1] == 3'd0)) |=>
      ((time_q[31:8] == $past(time_q[31:8])) && $stable(date_q)));

  // R7: weekday 7 wraps to 1
  a_r7_wday_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (mode_q[3:1] == 3'd3) && (time_q[27:24] == 4'd7)) |=>
      (time_q[27:24] == 4'd1));
endmodule

bind rtc_field_stepper rtc_fs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .mode_q  (mode_q),
  .ctrl_q  (ctrl_q),
  .time_q  (time_q),
  .date_q  (date_q)
);

// File: tb/rtc_field_stepper_tb_top.sv
module rtc_field_stepper_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_strb = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_mode, m_ctrl, m_time, m_date;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_field_stepper #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] s);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = s[i] ? d[i*8 +: 8] : old[i*8 +: 8];
    return r;
  endfunction

  // decimal model of one field step
  task automatic model_step();
    int v;
    case (m_mode[3:1])
      3'd0: begin v = (b2i(m_time[7:0]) + 1) % 60;  m_time[7:0]   = i2b(v); end
      3'd1: begin v = (b2i(m_time[15:8]) + 1) % 60; m_time[15:8]  = i2b(v); end
      3'd2: begin v = (b2i(m_time[23:16]) + 1) % 24; m_time[23:16] = i2b(v); end
      3'd3: m_time[27:24] = (m_time[27:24] == 4'd7) ? 4'd1 : m_time[27:24] + 4'd1;
      3'd4: begin v = b2i(m_date[7:0]);  v = (v == 31) ? 0 : v + 1; m_date[7:0]  = i2b(v); end
      3'd5: begin v = b2i(m_date[15:8]); v = (v == 12) ? 1 : v + 1; m_date[15:8] = i2b(v); end
      3'd6: begin v = (b2i(m_date[23:16]) + 1) % 100; m_date[23:16] = i2b(v); end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = AW'(a);
    #1 v = rd_data;
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    rd(0, v); check(req, v, m_mode);
    rd(1, v); check(req, v, m_ctrl);
    rd(2, v); check(req, v, m_time);
    rd(3, v); check(req, v, m_date);
    rd(9, v); check({req, " R11"}, v, 32'h0);
  endtask

  task automatic bwrite(input int a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d; wr_strb = s;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 0) m_mode = merge(m_mode, d, s);
    else if (a == 1) begin
      if (m_ctrl == 32'd1 && d == 32'd1) begin model_step(); m_ctrl = 32'd0; end
      else if (m_ctrl == 32'd0) m_ctrl = merge(m_ctrl, d, s);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_mode = '0; m_ctrl = '0; m_time = '0; m_date = '0;
  endtask

  task automatic step_field(input int code, input int n, input string req);
    bwrite(0, 32'(code) << 1, 4'hF);
    for (int i = 0; i < n; i++) begin
      bwrite(1, 32'd1, 4'hF);
      bwrite(1, 32'd1, 4'hF);
      check_all(req);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    m_mode = '0; m_ctrl = '0; m_time = '0; m_date = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R1 reset");

    // R5 seconds and minutes, full cycles through 0x59 -> 0x00
    step_field(0, 61, "R5 seconds");
    step_field(1, 61, "R5 minutes");
    // R6 hours through 0x23 -> 0x00
    step_field(2, 25, "R6 hours");
    // R7 weekday 0 -> 1 .. 7 -> 1
    step_field(3, 9, "R7 weekday");
    // R8 day and month
    step_field(4, 33, "R8 day");
    step_field(5, 14, "R8 month");
    // R9 low year through 0x99 -> 0x00
    step_field(6, 101, "R9 year");
    // R4 code 7 commits with no change, R10 holds throughout
    step_field(7, 2, "R4 code7");

    // R3 first write of 1 only arms; control reads 1, time unchanged
    bwrite(0, 32'h0, 4'hF);
    bwrite(1, 32'd1, 4'hF);
    check_all("R3 arm");
    // R3 control 1 with data 2 is ignored
    bwrite(1, 32'd2, 4'hF);
    check_all("R3 ignore");
    bwrite(1, 32'd1, 4'hF);
    check_all("R3 commit");

    // R2 masked writes
    bwrite(0, 32'hA5C3_7E11, 4'b0101);
    check_all("R2 mode mask");
    bwrite(1, 32'h1234_5600, 4'b0010);
    check_all("R2 ctrl mask");
    // R3 stuck control 0x5600 ignores further writes
    bwrite(1, 32'h0, 4'hF);
    check_all("R3 stuck");
    do_reset();
    check_all("R1 reset again");

    // R11 writes to read-only and unused offsets
    bwrite(2, 32'hFFFF_FFFF, 4'hF);
    bwrite(3, 32'hFFFF_FFFF, 4'hF);
    bwrite(7, 32'hFFFF_FFFF, 4'hF);
    check_all("R11 ignored writes");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [31:0] d;
      op = int'($urandom_range(0, 9));
      if (m_ctrl != 32'd0 && m_ctrl != 32'd1 && op > 7) begin
        do_reset();
        check_all("R1 random reset");
      end else if (op < 2) begin
        d = $urandom();
        bwrite(0, (op == 0) ? (32'($urandom_range(0, 7)) << 1) : d, 4'($urandom()));
        check_all("R2 random mode");
      end else if (op < 7) begin
        d = ($urandom_range(0, 9) == 0) ? $urandom() : 32'($urandom_range(0, 1));
        bwrite(1, d, ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF);
        check_all("R3 random ctrl");
      end else begin
        bwrite(int'($urandom_range(2, 15)), $urandom(), 4'($urandom()));
        check_all("R11 random ignored");
      end
    end

    rd(2, v);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule